// File: doc/BRIEF.md
# Secured OTP Programming Access Gate

This block stands between an external programmer and a small one-time-programmable store. The store holds a program area, a single configuration byte and a short user information area. The programmer reaches all three through one port. That port carries a region select, an address, write data, and read, write and erase strobes. Read data comes back one clock after the read strobe. A second, core-side port lets the executing processor fetch program bytes. That port can address only the program area, so the configuration and user bytes are out of its reach.

One bit of the configuration byte acts as a security fuse. Once the fuse is set, every external read of program space returns 0xFF, and writes to the program area and to the configuration byte are discarded. The configuration byte can still be read, and the user area stays readable and writable. An erase blanks the program area but leaves the fuse intact, so a secured part can never be programmed again. Discarded writes raise a sticky flag that only a dedicated clear strobe lowers.

The store burns bits one way, modelling one-time programming: a write to a program or user byte keeps the bitwise AND of the old and new values. Reset models a fresh blank part. Program and user bytes reset to 0xFF and the configuration byte resets to 0x80.

Top module: `otp_prog_gate`

## Requirements
- R1: After reset, `secured` and `reject` are 0, `pg_rdata` is 0xFF, and a configuration read returns 0x80.
- R2: With security clear, a read of program address A (region code 0) returns the stored byte on `pg_rdata` one clock after the `pg_rd` strobe.
- R3: An accepted write to a program or user byte stores the old value ANDed with `pg_wdata`, so bits only move from 1 to 0.
- R4: While bit 5 of the configuration byte is 1, every program-space read returns 0xFF, whatever is stored.
- R5: While secured, writes to program space and to the configuration byte leave the store unchanged and set `reject`.
- R6: The configuration byte (region code 1, address 0) reads back its current value whatever the security state.
- R7: The user area (region code 2, addresses 0 to 7) is readable and writable in every security state, and a write to it never sets `reject`.
- R8: `pg_erase` returns every program byte to 0xFF. It leaves the configuration byte and the fuse unchanged, so program and configuration writes are still rejected afterwards on a secured part. A write issued in the same cycle as an erase is discarded and flagged.
- R9: A read at an address outside the chosen region, or with region code 3, returns 0xFF. A write there is discarded and sets `reject`.
- R10: `core_data` returns the program byte at `core_addr` one clock later, regardless of the security state. The core port has no path to the configuration or user bytes.
- R11: `reject` stays set until `rej_clr` is pulsed. A new rejection in the same cycle as `rej_clr` keeps it set.
- R12: An accepted configuration write replaces the whole byte in one step. `secured` follows its bit 5 from the next cycle, and once set it never clears.

Top module ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset (models a blank part) |
| pg_region | input | 2 | Region select: 0 program, 1 configuration, 2 user, 3 none |
| pg_addr | input | ADDR_W | Byte address within the chosen region |
| pg_wdata | input | 8 | Write data |
| pg_rd | input | 1 | Read strobe |
| pg_wr | input | 1 | Write strobe |
| pg_erase | input | 1 | Program-area erase strobe |
| rej_clr | input | 1 | Clears the reject flag |
| pg_rdata | output | 8 | Read data, registered |
| core_addr | input | ADDR_W | Processor fetch address |
| core_data | output | 8 | Processor fetch data, registered |
| secured | output | 1 | Current state of the security fuse |
| reject | output | 1 | Sticky flag for discarded writes |

## Verification
Every cycle, the assertions check these properties: the fuse and the reject flag are sticky, secured program reads return 0xFF, the configuration byte is frozen once secured, configuration reads always return the current byte, and user writes and region-3 reads behave correctly. Only the bench scenarios can show the following: AND-burning of data across full sweeps of the program and user areas, the erase result and its interaction with a set fuse, core fetches during a secured state, and the exact one-cycle read latency against stored contents.

// File: rtl/otp_gate_pkg.sv
package otp_gate_pkg;

    localparam int          BYTE_W      = 8;
    localparam logic [7:0]  BLANK_BYTE  = 8'hFF;
    localparam logic [7:0]  CFG_FACTORY = 8'h80;
    localparam int          SEC_BIT     = 5;

    typedef enum logic [1:0] {
        RGN_PROG = 2'd0,
        RGN_CFG  = 2'd1,
        RGN_USER = 2'd2,
        RGN_NONE = 2'd3
    } region_e;

    // which store the programmer address lands in (at most one set)
    typedef struct packed {
        logic prog;
        logic cfg;
        logic user;
    } hit_t;

    // write decisions taken by the policy
    typedef struct packed {
        logic prog_wr;
        logic cfg_wr;
        logic user_wr;
        logic erase;
        logic reject;
    } wr_cmd_t;

    // one-way burn: bits can only be cleared
    function automatic logic [BYTE_W-1:0] otp_burn(input logic [BYTE_W-1:0] old_v,
                                                   input logic [BYTE_W-1:0] new_v);
        return old_v & new_v;
    endfunction

endpackage

// File: rtl/otp_region_decode.sv
module otp_region_decode
    import otp_gate_pkg::*;
#(
    parameter int PROG_BYTES = 1024,
    parameter int USER_BYTES = 8,
    parameter int ADDR_W     = 10
) (
    input  logic [1:0]        region,
    input  logic [ADDR_W-1:0] addr,
    output hit_t              hit
);
    localparam int PAD_W = 32 - ADDR_W;

    region_e     rgn;
    logic [31:0] addr_ext;

    always_comb begin
        rgn      = region_e'(region);
        addr_ext = {{PAD_W{1'b0}}, addr};
        hit.prog = (rgn == RGN_PROG) && (addr_ext < PROG_BYTES);
        hit.cfg  = (rgn == RGN_CFG)  && (addr_ext == 32'd0);
        hit.user = (rgn == RGN_USER) && (addr_ext < USER_BYTES);
    end

endmodule

// File: rtl/otp_write_policy.sv
module otp_write_policy
    import otp_gate_pkg::*;
(
    input  hit_t    hit,
    input  logic    wr,
    input  logic    erase,
    input  logic    secured,
    output wr_cmd_t cmd
);
    logic accepted;

    always_comb begin
        cmd.erase   = erase;
        cmd.prog_wr = wr && hit.prog && !secured && !erase;
        cmd.cfg_wr  = wr && hit.cfg  && !secured && !erase;
        cmd.user_wr = wr && hit.user && !erase;
        accepted    = cmd.prog_wr || cmd.cfg_wr || cmd.user_wr;
        cmd.reject  = wr && !accepted;
    end

endmodule

// File: rtl/otp_store.sv
module otp_store
    import otp_gate_pkg::*;
#(
    parameter int PROG_BYTES = 1024,
    parameter int USER_BYTES = 8,
    parameter int ADDR_W     = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  wr_cmd_t           cmd,
    input  hit_t              hit,
    input  logic [ADDR_W-1:0] addr,
    input  logic [BYTE_W-1:0] wdata,
    input  logic              rd,
    input  logic [ADDR_W-1:0] core_addr,
    output logic [BYTE_W-1:0] rdata,
    output logic [BYTE_W-1:0] core_data,
    output logic [BYTE_W-1:0] cfg_byte
);
    localparam int PIDX_W = (PROG_BYTES > 1) ? $clog2(PROG_BYTES) : 1;
    localparam int UIDX_W = (USER_BYTES > 1) ? $clog2(USER_BYTES) : 1;
    localparam int PAD_W  = 32 - ADDR_W;

    logic [BYTE_W-1:0] prog_q [PROG_BYTES];
    logic [BYTE_W-1:0] user_q [USER_BYTES];
    logic [BYTE_W-1:0] cfg_q;
    logic [BYTE_W-1:0] rdata_q;
    logic [BYTE_W-1:0] core_q;

    logic [PIDX_W-1:0] pidx;
    logic [UIDX_W-1:0] uidx;
    logic [PIDX_W-1:0] cidx;
    logic              core_hit;
    logic              secured_now;

    assign pidx        = addr[PIDX_W-1:0];
    assign uidx        = addr[UIDX_W-1:0];
    assign cidx        = core_addr[PIDX_W-1:0];
    assign core_hit    = {{PAD_W{1'b0}}, core_addr} < PROG_BYTES;
    assign secured_now = cfg_q[SEC_BIT];

    // program area: blank on reset and erase, burn on write
    always_ff @(posedge clk) begin
        if (rst || cmd.erase) begin
            for (int i = 0; i < PROG_BYTES; i++) prog_q[i] <= BLANK_BYTE;
        end else if (cmd.prog_wr) begin
            prog_q[pidx] <= otp_burn(prog_q[pidx], wdata);
        end
    end

    // user area: never erased, never locked
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < USER_BYTES; i++) user_q[i] <= BLANK_BYTE;
        end else if (cmd.user_wr) begin
            user_q[uidx] <= otp_burn(user_q[uidx], wdata);
        end
    end

    // configuration byte: whole-byte update while unlocked
    always_ff @(posedge clk) begin
        if (rst)             cfg_q <= CFG_FACTORY;
        else if (cmd.cfg_wr) cfg_q <= wdata;
    end

    // programmer read path, one clock of latency
    always_ff @(posedge clk) begin
        if (rst) begin
            rdata_q <= BLANK_BYTE;
        end else if (rd) begin
            if (hit.prog)      rdata_q <= secured_now ? BLANK_BYTE : prog_q[pidx];
            else if (hit.cfg)  rdata_q <= cfg_q;
            else if (hit.user) rdata_q <= user_q[uidx];
            else               rdata_q <= BLANK_BYTE;
        end
    end

    // core fetch path: program area only
    always_ff @(posedge clk) begin
        if (rst)           core_q <= BLANK_BYTE;
        else if (core_hit) core_q <= prog_q[cidx];
        else               core_q <= BLANK_BYTE;
    end

    assign rdata     = rdata_q;
    assign core_data = core_q;
    assign cfg_byte  = cfg_q;

endmodule

// File: rtl/otp_prog_gate.sv
module otp_prog_gate
    import otp_gate_pkg::*;
#(
    parameter int PROG_BYTES = 1024,
    parameter int USER_BYTES = 8,
    parameter int ADDR_W     = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        pg_region,
    input  logic [ADDR_W-1:0] pg_addr,
    input  logic [7:0]        pg_wdata,
    input  logic              pg_rd,
    input  logic              pg_wr,
    input  logic              pg_erase,
    input  logic              rej_clr,
    output logic [7:0]        pg_rdata,
    input  logic [ADDR_W-1:0] core_addr,
    output logic [7:0]        core_data,
    output logic              secured,
    output logic              reject
);
    hit_t              hit;
    wr_cmd_t           cmd;
    logic [BYTE_W-1:0] cfg_byte;
    logic              reject_q;

    otp_region_decode #(
        .PROG_BYTES(PROG_BYTES), .USER_BYTES(USER_BYTES), .ADDR_W(ADDR_W)
    ) u_decode (
        .region(pg_region), .addr(pg_addr), .hit(hit)
    );

    otp_write_policy u_policy (
        .hit(hit), .wr(pg_wr), .erase(pg_erase), .secured(secured), .cmd(cmd)
    );

    otp_store #(
        .PROG_BYTES(PROG_BYTES), .USER_BYTES(USER_BYTES), .ADDR_W(ADDR_W)
    ) u_store (
        .clk(clk), .rst(rst), .cmd(cmd), .hit(hit), .addr(pg_addr),
        .wdata(pg_wdata), .rd(pg_rd), .core_addr(core_addr),
        .rdata(pg_rdata), .core_data(core_data), .cfg_byte(cfg_byte)
    );

    assign secured = cfg_byte[SEC_BIT];

    always_ff @(posedge clk) begin
        if (rst)             reject_q <= 1'b0;
        else if (cmd.reject) reject_q <= 1'b1;
        else if (rej_clr)    reject_q <= 1'b0;
    end

    assign reject = reject_q;

endmodule

// File: rtl/otp_prog_gate_chk.sv
module otp_prog_gate_chk #(
    parameter int ADDR_W     = 10,
    parameter int USER_BYTES = 8
) (
    input logic              clk,
    input logic              rst,
    input logic [1:0]        pg_region,
    input logic [ADDR_W-1:0] pg_addr,
    input logic              pg_rd,
    input logic              pg_wr,
    input logic              pg_erase,
    input logic              rej_clr,
    input logic [7:0]        pg_rdata,
    input logic              secured,
    input logic              reject,
    input logic [7:0]        cfg_q
);
    logic user_in_range;
    assign user_in_range = ({{(32-ADDR_W){1'b0}}, pg_addr} < USER_BYTES);

    a_r12_fuse_sticky: assert property (@(posedge clk) disable iff (rst)
        secured |=> secured);

    a_r11_reject_sticky: assert property (@(posedge clk) disable iff (rst)
        (reject && !rej_clr) |=> reject);

    a_r4_secure_read_blank: assert property (@(posedge clk) disable iff (rst)
        (pg_rd && secured && pg_region == 2'd0) |=> (pg_rdata == 8'hFF));

    a_r5_cfg_frozen: assert property (@(posedge clk) disable iff (rst)
        secured |=> $stable(cfg_q));

    a_r5_secure_prog_write_flagged: assert property (@(posedge clk) disable iff (rst)
        (pg_wr && secured && pg_region == 2'd0) |=> reject);

    a_r6_cfg_readable: assert property (@(posedge clk) disable iff (rst)
        (pg_rd && pg_region == 2'd1 && pg_addr == '0) |=> (pg_rdata == $past(cfg_q)));

    a_r7_user_write_clean: assert property (@(posedge clk) disable iff (rst)
        (pg_wr && pg_region == 2'd2 && user_in_range && !pg_erase && !reject) |=> !reject);

    a_r9_none_region_blank: assert property (@(posedge clk) disable iff (rst)
        (pg_rd && pg_region == 2'd3) |=> (pg_rdata == 8'hFF));

endmodule

bind otp_prog_gate otp_prog_gate_chk #(.ADDR_W(ADDR_W), .USER_BYTES(USER_BYTES)) u_chk (
    .clk(clk), .rst(rst), .pg_region(pg_region), .pg_addr(pg_addr),
    .pg_rd(pg_rd), .pg_wr(pg_wr), .pg_erase(pg_erase), .rej_clr(rej_clr),
    .pg_rdata(pg_rdata), .secured(secured), .reject(reject), .cfg_q(cfg_byte)
);

// File: tb/otp_prog_gate_test.sv
`timescale 1ns/1ps
module otp_prog_gate_test;
    localparam int PROG = 1024;
    localparam int USER = 8;
    localparam int AW   = 10;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [1:0]    pg_region = 2'd0;
    logic [AW-1:0] pg_addr = '0;
    logic [7:0]    pg_wdata = '0;
    logic          pg_rd = 1'b0, pg_wr = 1'b0, pg_erase = 1'b0, rej_clr = 1'b0;
    logic [7:0]    pg_rdata, core_data;
    logic [AW-1:0] core_addr = '0;
    logic          secured, reject;

    int  n_cmp = 0;
    int  n_bad = 0;
    bit  done  = 0;

    logic [7:0] exp_prog [PROG];
    logic [7:0] exp_user [USER];
    logic [7:0] exp_cfg;

    always #5 clk = ~clk;

    otp_prog_gate #(.PROG_BYTES(PROG), .USER_BYTES(USER), .ADDR_W(AW)) uut (
        .clk(clk), .rst(rst), .pg_region(pg_region), .pg_addr(pg_addr),
        .pg_wdata(pg_wdata), .pg_rd(pg_rd), .pg_wr(pg_wr), .pg_erase(pg_erase),
        .rej_clr(rej_clr), .pg_rdata(pg_rdata), .core_addr(core_addr),
        .core_data(core_data), .secured(secured), .reject(reject)
    );

    task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %02h expected %02h", req, got, exp);
        end
    endtask

    task automatic do_wr(input logic [1:0] rg, input int a, input logic [7:0] d);
        @(negedge clk);
        pg_region = rg; pg_addr = AW'(a); pg_wdata = d; pg_wr = 1'b1;
        @(negedge clk);
        pg_wr = 1'b0;
    endtask

    task automatic do_rd(input logic [1:0] rg, input int a, output logic [7:0] d);
        @(negedge clk);
        pg_region = rg; pg_addr = AW'(a); pg_rd = 1'b1;
        @(negedge clk);
        pg_rd = 1'b0;
        d = pg_rdata;
    endtask

    task automatic do_fetch(input int a, output logic [7:0] d);
        @(negedge clk);
        core_addr = AW'(a);
        @(negedge clk);
        d = core_data;
    endtask

    task automatic do_clear();
        @(negedge clk); rej_clr = 1'b1;
        @(negedge clk); rej_clr = 1'b0;
    endtask

    function automatic logic [7:0] pat_a(input int a);
        return 8'((a * 7 + 3) & 255);
    endfunction
    function automatic logic [7:0] pat_b(input int a);
        return 8'(((a * 13) + (a >> 3)) & 255) | 8'h81;
    endfunction

    initial begin
        #1ms;
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: got %0d expected %0d", 0, 1);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] d;
        for (int i = 0; i < PROG; i++) exp_prog[i] = 8'hFF;
        for (int i = 0; i < USER; i++) exp_user[i] = 8'hFF;
        exp_cfg = 8'h80;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check("R1 secured", {7'd0, secured}, 8'd0);
        check("R1 reject",  {7'd0, reject},  8'd0);
        check("R1 rdata",   pg_rdata, 8'hFF);
        do_rd(2'd1, 0, d); check("R1 cfg factory", d, 8'h80);

        // R2 blank program sweep
        for (int a = 0; a < PROG; a++) begin
            do_rd(2'd0, a, d); check("R2 blank", d, 8'hFF);
        end
        // R3 two burns per byte, then full read sweep
        for (int a = 0; a < PROG; a++) begin
            do_wr(2'd0, a, pat_a(a));
            do_wr(2'd0, a, pat_b(a));
            exp_prog[a] = pat_a(a) & pat_b(a);
        end
        check("R3 no reject", {7'd0, reject}, 8'd0);
        for (int a = 0; a < PROG; a++) begin
            do_rd(2'd0, a, d); check("R2 R3 burned", d, exp_prog[a]);
        end
        // R10 core fetch sweep
        for (int a = 0; a < PROG; a += 3) begin
            do_fetch(a, d); check("R10 fetch", d, exp_prog[a]);
        end

        // R7 user area burns and reads
        for (int u = 0; u < USER; u++) begin
            do_wr(2'd2, u, 8'hF0 | 8'(u));
            do_wr(2'd2, u, 8'h3F);
            exp_user[u] = (8'hF0 | 8'(u)) & 8'h3F;
        end
        check("R7 no reject", {7'd0, reject}, 8'd0);
        for (int u = 0; u < USER; u++) begin
            do_rd(2'd2, u, d); check("R7 user", d, exp_user[u]);
        end

        // R9 out-of-range reads and writes
        do_rd(2'd2, USER, d);   check("R9 user oor", d, 8'hFF);
        do_rd(2'd1, 1, d);      check("R9 cfg oor", d, 8'hFF);
        do_rd(2'd3, 5, d);      check("R9 none region", d, 8'hFF);
        do_wr(2'd2, USER + 1, 8'h00);
        @(negedge clk); check("R9 oor write flagged", {7'd0, reject}, 8'd1);
        // R11 sticky then clear
        repeat (3) @(negedge clk);
        check("R11 sticky", {7'd0, reject}, 8'd1);
        do_clear();
        check("R11 cleared", {7'd0, reject}, 8'd0);

        // R12 whole-byte config update without fuse
        do_wr(2'd1, 0, 8'h55); exp_cfg = 8'h55;
        check("R12 not secured", {7'd0, secured}, 8'd0);
        do_rd(2'd1, 0, d); check("R12 cfg value", d, exp_cfg);
        // R12 set fuse with other bits
        do_wr(2'd1, 0, 8'h75); exp_cfg = 8'h75;
        check("R12 secured", {7'd0, secured}, 8'd1);
        do_rd(2'd1, 0, d); check("R12 R6 cfg secured", d, exp_cfg);

        // R4 secured program reads blank
        for (int a = 0; a < PROG; a += 5) begin
            do_rd(2'd0, a, d); check("R4 secured read", d, 8'hFF);
        end
        // R10 core unaffected by fuse
        for (int a = 1; a < PROG; a += 37) begin
            do_fetch(a, d); check("R10 fetch secured", d, exp_prog[a]);
        end
        // R5 program write rejected
        do_wr(2'd0, 10, 8'h00);
        @(negedge clk); check("R5 prog reject", {7'd0, reject}, 8'd1);
        do_fetch(10, d); check("R5 prog unchanged", d, exp_prog[10]);
        do_clear();
        // R5 config write rejected, R6 still readable
        do_wr(2'd1, 0, 8'h00);
        @(negedge clk); check("R5 cfg reject", {7'd0, reject}, 8'd1);
        do_rd(2'd1, 0, d); check("R5 R6 cfg unchanged", d, exp_cfg);
        check("R12 fuse holds", {7'd0, secured}, 8'd1);
        // R11 new rejection in same cycle as clear keeps flag
        @(negedge clk);
        pg_region = 2'd0; pg_addr = '0; pg_wdata = 8'h00; pg_wr = 1'b1; rej_clr = 1'b1;
        @(negedge clk);
        pg_wr = 1'b0; rej_clr = 1'b0;
        check("R11 set beats clear", {7'd0, reject}, 8'd1);
        do_clear();
        check("R11 cleared again", {7'd0, reject}, 8'd0);

        // R7 user writable while secured
        do_wr(2'd2, 3, 8'h0F); exp_user[3] = exp_user[3] & 8'h0F;
        check("R7 secured no reject", {7'd0, reject}, 8'd0);
        do_rd(2'd2, 3, d); check("R7 secured user", d, exp_user[3]);

        // R8 erase on secured part
        @(negedge clk); pg_erase = 1'b1;
        @(negedge clk); pg_erase = 1'b0;
        for (int i = 0; i < PROG; i++) exp_prog[i] = 8'hFF;
        check("R8 fuse kept", {7'd0, secured}, 8'd1);
        for (int a = 0; a < PROG; a += 7) begin
            do_fetch(a, d); check("R8 erased", d, 8'hFF);
        end
        do_rd(2'd1, 0, d); check("R8 cfg kept", d, exp_cfg);
        do_rd(2'd2, 3, d); check("R8 user kept", d, exp_user[3]);
        do_wr(2'd0, 20, 8'h12);
        @(negedge clk); check("R8 still locked", {7'd0, reject}, 8'd1);
        do_fetch(20, d); check("R8 no program", d, 8'hFF);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule